// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is one general-purpose I/O port with 32 pins, reached through a plain write-strobe register bus whose reads are combinational. Software sets output values and per-pin drive enables and samples the pins through a synchronised input register. Each pin can also be watched for a rising edge, a falling edge, a high level or a low level. Events land in a sticky status register, and enabled status bits are merged into one port interrupt line.

Every writable register appears three times in the address map. There is a plain-write address, a set alias that ORs in the ones written, and a clear alias that removes the ones written. Single pins can therefore change with no read-modify-write. Interrupt capture has two gates. A per-pin detect enable decides whether a pin can set its status bit, and a per-pin interrupt enable decides whether that status bit can reach the port interrupt. Software can get both-edge detection by flipping a pin's polarity bit after each event, because a polarity change never creates an event by itself.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset with rst_n low, every register reads zero, pin_oe and pin_out are zero and irq is low.
- R2: Address bits [6:4] select a register: 0 output data, 1 input data, 2 output enable, 3 detect enable, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Bits [3:2] select the alias. Alias 0 (offset 0x0) loads the word. Alias 1 (offset 0x4) sets the bits written as one. Alias 2 (offset 0x8) clears the bits written as one. Bits written as zero are unchanged, and alias 3 (offset 0xC) is ignored.
- R3: pin_out follows the output-data register and pin_oe follows the output-enable register, where 1 drives the pin as an output.
- R4: The input-data register returns pin_in after two clock edges of synchronisation, and writes to it have no effect.
- R5: A pin's mode is {polarity, level select}. 00 is falling edge, 01 is low level, 10 is rising edge and 11 is high level.
- R6: In edge mode, one transition in the selected direction sets the pin's status bit. The bit stays set until software writes a one to the status clear alias.
- R7: In level mode, the status bit is set on every cycle the pin is at the selected level, so a clear has no lasting effect while that level persists.
- R8: A pin whose detect-enable bit is 0 never sets its status bit.
- R9: irq is high exactly when the bitwise AND of status and interrupt enable is non-zero.
- R10: Changing a pin's polarity while its input is steady raises no status.
- R11: When a detected event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R12: Plain writes and set-alias writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 7 | Register select [6:4] and alias select [3:2] |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined port interrupt |

## Verification
Two things can hit one status bit in the same cycle: a hardware event that sets it and a software clear that removes it. The bench provokes this in two ways. It holds a pin at its active level in level mode and then writes the clear alias. It also times a clear write so that its clock edge is the same edge on which a synchronised edge event lands. Both times the bit is read back afterwards and must be set. Random configurations with random pin steps are checked against a bench model of the four modes, and that model includes the bits that level mode sets again right after a clear.

// File: rtl/gpio_pkg.sv
// Package: shared register indices, alias codes and widths for the GPIO port.
// Assumes one register per 0x10 block and alias selection in address bits [3:2].
package gpio_pkg;
    localparam int unsigned REG_IDX_W = 3;
    localparam int unsigned ALIAS_W   = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_DOUT = 3'd0,
        RG_DIN  = 3'd1,
        RG_OE   = 3'd2,
        RG_DETE = 3'd3,
        RG_IEN  = 3'd4,
        RG_LVL  = 3'd5,
        RG_POL  = 3'd6,
        RG_STAT = 3'd7
    } reg_idx_e;

    typedef enum logic [ALIAS_W-1:0] {
        AL_LOAD = 2'd0,
        AL_SET  = 2'd1,
        AL_CLR  = 2'd2,
        AL_NONE = 2'd3
    } alias_e;

    // True for registers that software may load, set and clear freely.
    function automatic logic is_plain_rw(input int unsigned idx);
        return !(idx == RG_DIN || idx == RG_STAT);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_alias_reg.sv
// Module: one register with load, set-alias and clear-alias write semantics.
// Assumes the caller qualifies wr_en with the register's own address decode.
module gpio_alias_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [gpio_pkg::ALIAS_W-1:0] alias_sel,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [WIDTH-1:0]            q
);
    import gpio_pkg::*;

    logic [WIDTH-1:0] q_next;

    // Purpose: compute the next value from the selected alias.
    always_comb begin
        q_next = q;
        if (wr_en) begin
            case (alias_e'(alias_sel))
                AL_LOAD: q_next = wr_data;
                AL_SET:  q_next = q | wr_data;
                AL_CLR:  q_next = q & ~wr_data;
                default: q_next = q;
            endcase
        end
    end

    // Purpose: hold the register value, zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin edge/level detection feeding a sticky status register.
// Assumes pin_s is already synchronised; a hardware event beats a clear.
module gpio_irq_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] det_en,
    input  logic [WIDTH-1:0] lvl_sel,
    input  logic [WIDTH-1:0] pol_sel,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] stat
);
    logic [WIDTH-1:0] pin_prev;
    logic [WIDTH-1:0] hit;

    // Purpose: remember last cycle's synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= '0;
        else        pin_prev <= pin_s;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            logic rise, fall, at_lvl;
            // Purpose: decide whether pin i raises an event this cycle.
            always_comb begin
                rise   = pin_s[i] & ~pin_prev[i];
                fall   = ~pin_s[i] & pin_prev[i];
                at_lvl = ~(pin_s[i] ^ pol_sel[i]);
                if (lvl_sel[i]) hit[i] = det_en[i] & at_lvl;
                else            hit[i] = det_en[i] & (pol_sel[i] ? rise : fall);
            end
        end
    endgenerate

    // Purpose: sticky status; clears first, then new events set.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_mask) | hit;
    end
endmodule

// File: rtl/gpio_irq_port.sv
// Module: top of the 32-pin GPIO port with aliased registers and interrupt.
// Assumes a single-cycle write strobe and combinational reads on addr.
module gpio_irq_port #(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    import gpio_pkg::*;

    localparam int unsigned NREG     = 1 << REG_IDX_W;
    localparam int unsigned IDX_LSB  = 2 + ALIAS_W;
    localparam int unsigned SYNC_LEN = 2;

    logic [REG_IDX_W-1:0] reg_idx;
    logic [ALIAS_W-1:0]   alias_sel;
    logic [NPINS-1:0]     rw_q [NREG];
    logic [NPINS-1:0]     pin_sync;
    logic [NPINS-1:0]     stat_q;
    logic [NPINS-1:0]     stat_clr;

    assign reg_idx   = addr[IDX_LSB +: REG_IDX_W];
    assign alias_sel = addr[2 +: ALIAS_W];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            if (is_plain_rw(g)) begin : g_rw
                gpio_alias_reg #(.WIDTH(NPINS)) u_reg (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .wr_en     (wr_en && (reg_idx == REG_IDX_W'(g))),
                    .alias_sel (alias_sel),
                    .wr_data   (wr_data),
                    .q         (rw_q[g])
                );
            end else begin : g_ro
                assign rw_q[g] = '0;
            end
        end
    endgenerate

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Purpose: status accepts only the clear alias.
    always_comb begin
        stat_clr = '0;
        if (wr_en && reg_idx == RG_STAT && alias_e'(alias_sel) == AL_CLR)
            stat_clr = wr_data;
    end

    gpio_irq_detect #(.WIDTH(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_sync),
        .det_en   (rw_q[RG_DETE]),
        .lvl_sel  (rw_q[RG_LVL]),
        .pol_sel  (rw_q[RG_POL]),
        .clr_mask (stat_clr),
        .stat     (stat_q)
    );

    // Purpose: combinational read mux over the register blocks.
    always_comb begin
        case (reg_idx_e'(reg_idx))
            RG_DIN:  rd_data = pin_sync;
            RG_STAT: rd_data = stat_q;
            default: rd_data = rw_q[reg_idx];
        endcase
    end

    assign pin_out = rw_q[RG_DOUT];
    assign pin_oe  = rw_q[RG_OE];
    assign irq     = |(stat_q & rw_q[RG_IEN]);
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Module: assertion checker for gpio_irq_port, bound to every instance.
// Assumes the parent's internal names stat_q and rw_q.
module gpio_irq_port_chk #(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    addr,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] stat,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] dete,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq
);
    localparam logic [AW-1:0] STAT_CLR = AW'(8'h78);
    localparam logic [AW-1:0] OE_SET   = AW'(8'h24);
    localparam logic [AW-1:0] OE_CLR   = AW'(8'h28);

    // R6 status bits only fall through a clear-alias write
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == STAT_CLR) |=> ((stat & $past(stat)) == $past(stat)));

    // R8 a newly set status bit had its detect enable on
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(dete)) == '0));

    // R9 interrupt follows enabled status
    a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ien) != '0) |-> irq);
    a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ien) == '0) |-> !irq);

    // R2 set alias forces ones, clear alias forces zeros
    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OE_SET) |=> ((pin_oe & $past(wr_data)) == $past(wr_data)));
    a_r2_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OE_CLR) |=> ((pin_oe & $past(wr_data)) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .stat    (stat_q),
    .ien     (rw_q[4]),
    .dete    (rw_q[3]),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int N = 32;
    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [6:0] addr = '0;
    logic [N-1:0] wr_data = '0, rd_data, pin_in = '0, pin_out, pin_oe;
    logic irq;
    int checks = 0, errors = 0;
    logic [N-1:0] m [8];

    gpio_irq_port dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int al, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1; addr = 7'((idx << 4) | (al << 2)); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int idx, output logic [N-1:0] v);
        @(negedge clk);
        addr = 7'(idx << 4);
        #1 v = rd_data;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    function automatic logic [N-1:0] apply(input logic [N-1:0] q, input int al, input logic [N-1:0] d);
        case (al)
            0: return d;
            1: return q | d;
            2: return q & ~d;
            default: return q;
        endcase
    endfunction

    // Expected new status bits when pins step from o to n under a config.
    function automatic logic [N-1:0] events(input logic [N-1:0] o, input logic [N-1:0] n,
            input logic [N-1:0] pe, input logic [N-1:0] lv, input logic [N-1:0] po);
        return pe & ((lv & ~(n ^ po)) | (~lv & po & n & ~o) | (~lv & ~po & ~n & o));
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] v, o, n, e0, exp;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        for (int i = 0; i < 8; i++) m[i] = '0;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            check(v == '0, "R1", v, '0);
        end
        check(pin_oe == '0 && pin_out == '0 && irq == 0, "R1 pins", pin_oe | pin_out, '0);

        // R2 R3 random alias writes to config registers (detect enable stays 0)
        for (int k = 0; k < 150; k++) begin
            int idx, al;
            logic [N-1:0] d;
            int pick[5] = '{0, 2, 4, 5, 6};
            idx = pick[$urandom_range(0, 4)];
            al = $urandom_range(0, 3);
            d = $urandom();
            wr(idx, al, d);
            m[idx] = apply(m[idx], al, d);
            rd(idx, v);
            check(v == m[idx], "R2", v, m[idx]);
            check(pin_out == m[0], "R3 out", pin_out, m[0]);
            check(pin_oe == m[2], "R3 oe", pin_oe, m[2]);
        end

        // R12 plain and set writes to status do nothing; R4 din writes ignored
        wr(7, 0, '1);
        wr(7, 1, '1);
        rd(7, v);
        check(v == '0, "R12", v, '0);
        wr(1, 0, 32'hffff0000);
        rd(1, v);
        check(v == '0, "R4 din write", v, '0);

        // R4 input synchronised
        set_pins(32'ha5c3_0f81);
        @(negedge clk);
        rd(1, v);
        check(v == 32'ha5c3_0f81, "R4", v, 32'ha5c3_0f81);

        // R5 R6 R7 R8 R9 random detection rounds
        o = pin_in;
        for (int r = 0; r < 40; r++) begin
            m[3] = $urandom(); m[4] = $urandom(); m[5] = $urandom(); m[6] = $urandom();
            wr(3, 0, m[3]); wr(4, 0, m[4]); wr(5, 0, m[5]); wr(6, 0, m[6]);
            wr(7, 2, '1);
            repeat (2) @(negedge clk);
            e0 = m[3] & m[5] & ~(o ^ m[6]);
            rd(7, v);
            check(v == e0, "R7 after clear", v, e0);
            n = $urandom();
            set_pins(n);
            repeat (5) @(negedge clk);
            exp = e0 | events(o, n, m[3], m[5], m[6]);
            rd(7, v);
            check(v == exp, "R6 R5 R8 status", v, exp);
            check(irq == |(exp & m[4]), "R9 irq", {31'b0, irq}, {31'b0, |(exp & m[4])});
            o = n;
        end

        // R10 polarity toggles on steady input raise nothing (edge mode)
        wr(5, 0, '0); wr(3, 0, '1); wr(4, 0, '0);
        wr(7, 2, '1);
        for (int t = 0; t < 4; t++) begin
            wr(6, 0, $urandom());
            repeat (3) @(negedge clk);
        end
        rd(7, v);
        check(v == '0, "R10", v, '0);

        // R10 both-edge emulation on pin 5: rising, flip, falling
        set_pins('0);
        repeat (4) @(negedge clk);
        wr(6, 0, 32'h20); wr(7, 2, '1);
        set_pins(32'h20);
        repeat (5) @(negedge clk);
        rd(7, v);
        check(v == 32'h20, "R6 rise", v, 32'h20);
        wr(7, 2, 32'h20); wr(6, 2, 32'h20);
        repeat (4) @(negedge clk);
        rd(7, v);
        check(v == '0, "R10 flip", v, '0);
        set_pins('0);
        repeat (5) @(negedge clk);
        rd(7, v);
        check(v == 32'h20, "R10 fall", v, 32'h20);

        // R11 edge event and clear on the same edge
        wr(6, 0, 32'h100); wr(7, 2, '1);
        set_pins(32'h100);
        @(negedge clk);
        wr(7, 2, 32'h100);
        repeat (2) @(negedge clk);
        rd(7, v);
        check(v[8] == 1'b1, "R11 edge collision", v, 32'h100);

        // R11 R7 level persists through clear
        wr(5, 0, 32'h100); wr(6, 0, 32'h100);
        wr(7, 2, '1);
        rd(7, v);
        check(v == 32'h100, "R11 level collision", v, 32'h100);
        wr(4, 0, 32'h100);
        @(negedge clk);
        check(irq == 1, "R9 on", {31'b0, irq}, 1);
        wr(4, 2, 32'h100);
        @(negedge clk);
        check(irq == 0, "R9 off", {31'b0, irq}, 0);

        // R1 reset clears everything again
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        rd(7, v);
        check(v == '0 && pin_oe == '0, "R1 rereset", v, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule